// File: doc/BRIEF.md
# Auto-Negotiation Page Receive Status

This block sits beside an Ethernet auto-negotiation engine. It watches the link code words that the partner sends. A page counts as received only when the same word arrives several times in a row. When that happens, the block latches the word into a partner-ability register. It also judges parallel-detection faults at the moment the negotiation wait timer expires.

Both results are shown in an expansion status word on a read-only management register port. The two event bits in that word are sticky and clear when the word is read. Read data is combinational from the address. The read strobe marks the cycle whose closing clock edge applies the clear-on-read side effect.

Top module: `an_page_status`

## Requirements
- R1: The page-received flag (address 6, bit 1) rises at the clock edge that accepts the MATCH_CNT-th consecutive identical word with `cw_valid` high (third with the default). Words seen while `cw_valid` is low are not counted.
- R2: A valid word that differs from the previous valid word restarts the consecutive count at 1.
- R3: Further identical words that only repeat an already accepted page do not set page-received again.
- R4: On the accepting edge the matched word is stored, and reads of address 5 return it until the next accepted page.
- R5: Address 6 layout: bit 4 is the fault, bit 3 is partner next-page (bit 15 of the stored word), bit 2 follows `np_local`, bit 1 is page-received and bit 0 is partner-negotiation-able. Bits 15..5 read 0.
- R6: With `rd_en` high and `rd_addr` equal to 6, `rd_data` shows the values held before the edge. Page-received and fault are 0 after that edge.
- R7: At a `timer_exp` pulse the fault bit is set when the number of `link_ready` bits that are high is 0 or more than 1. It is not set when exactly one bit is high, and nothing is set without the pulse.
- R8: When a set event and a clearing read meet on one edge, the bit ends up set.
- R9: After synchronous reset every status bit, the match count and the stored word are 0.
- R10: Bit 0 is set by the first accepted page and stays set through reads until reset.
- R11: Reads of any address other than 5 and 6 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | A new partner code word is present |
| cw_word | input | 16 | Partner code word |
| link_ready | input | NUM_TECH | Per-technology link-integrity ready flags |
| timer_exp | input | 1 | Wait-timer expiry pulse |
| np_local | input | 1 | Local next-page capability |
| rd_en | input | 1 | Management read strobe |
| rd_addr | input | 5 | Management register address |
| rd_data | output | 16 | Read data for `rd_addr` |

## Verification
The bench builds the block with its defaults: MATCH_CNT of 3 and NUM_TECH of 3. With three ready flags, the fault rule can be driven with zero, one, two and three ready functions, so every branch of the count is reached. A match length of 3 leaves room to break a run after two words and show that counting restarts. The bench also lines up a third matching word, or a timer pulse, on the same edge as a clearing read.

// File: rtl/an_pkg.sv
package an_pkg;

    localparam int unsigned CW_W       = 16;
    localparam int unsigned REG_ADDR_W = 5;
    localparam int unsigned NP_POS     = 15;

    localparam logic [REG_ADDR_W-1:0] ADDR_PARTNER = 5'd5;
    localparam logic [REG_ADDR_W-1:0] ADDR_EXP     = 5'd6;

    // Field order matters: fault lands on bit 4, lpana on bit 0.
    typedef struct packed {
        logic fault;
        logic lp_np;
        logic loc_np;
        logic prcvd;
        logic lpana;
    } exp_stat_t;

    localparam int unsigned STAT_W = $bits(exp_stat_t);

    function automatic logic [CW_W-1:0] pack_exp(input exp_stat_t s);
        return {{(CW_W-STAT_W){1'b0}}, s};
    endfunction

    function automatic logic is_clear_read(input logic en,
                                           input logic [REG_ADDR_W-1:0] a);
        return en && (a == ADDR_EXP);
    endfunction

endpackage

// File: rtl/an_cw_matcher.sv
module an_cw_matcher
    import an_pkg::*;
#(
    parameter int unsigned MATCH_CNT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cw_valid,
    input  logic [CW_W-1:0] cw_word,
    output logic            page_evt,
    output logic [CW_W-1:0] page_word
);
    localparam int unsigned CNT_W = $clog2(MATCH_CNT + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MATCH_CNT);

    logic [CW_W-1:0]  last_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             acc_q, acc_d;
    logic             same;

    always_comb begin
        same = (cnt_q != '0) && (cw_word == last_q);
        if (same)
            cnt_d = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + CNT_W'(1);
        else
            cnt_d = CNT_W'(1);
        page_evt  = cw_valid && (cnt_d == CNT_TOP) && !(same && acc_q);
        acc_d     = same ? (acc_q | page_evt) : page_evt;
        page_word = cw_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            cnt_q  <= '0;
            acc_q  <= 1'b0;
        end else if (cw_valid) begin
            last_q <= cw_word;
            cnt_q  <= cnt_d;
            acc_q  <= acc_d;
        end
    end

endmodule

// File: rtl/an_pd_detect.sv
module an_pd_detect #(
    parameter int unsigned NUM_TECH = 3
) (
    input  logic [NUM_TECH-1:0] link_ready,
    input  logic                timer_exp,
    output logic                fault_evt
);
    localparam int unsigned TALLY_W = $clog2(NUM_TECH + 1);

    logic [TALLY_W-1:0] tally;

    always_comb begin
        tally = '0;
        for (int i = 0; i < NUM_TECH; i++)
            tally = tally + TALLY_W'(link_ready[i]);
        fault_evt = timer_exp && (tally != TALLY_W'(1));
    end

endmodule

// File: rtl/an_stat_regs.sv
module an_stat_regs
    import an_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  page_evt,
    input  logic [CW_W-1:0]       page_word,
    input  logic                  fault_evt,
    input  logic                  np_local,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output exp_stat_t             stat,
    output logic [CW_W-1:0]       rd_data
);
    logic [CW_W-1:0] partner_q;
    logic            prcvd_q, fault_q, lpana_q;
    logic            clr;

    assign clr = is_clear_read(rd_en, rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            partner_q <= '0;
            prcvd_q   <= 1'b0;
            fault_q   <= 1'b0;
            lpana_q   <= 1'b0;
        end else begin
            // set has priority over the clear of the same edge
            prcvd_q <= page_evt  | (prcvd_q & ~clr);
            fault_q <= fault_evt | (fault_q & ~clr);
            lpana_q <= lpana_q | page_evt;
            if (page_evt)
                partner_q <= page_word;
        end
    end

    always_comb begin
        stat.fault  = fault_q;
        stat.lp_np  = partner_q[NP_POS];
        stat.loc_np = np_local;
        stat.prcvd  = prcvd_q;
        stat.lpana  = lpana_q;
        case (rd_addr)
            ADDR_PARTNER: rd_data = partner_q;
            ADDR_EXP:     rd_data = pack_exp(stat);
            default:      rd_data = '0;
        endcase
    end

endmodule

// File: rtl/an_page_status.sv
module an_page_status
    import an_pkg::*;
#(
    parameter int unsigned MATCH_CNT = 3,
    parameter int unsigned NUM_TECH  = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cw_valid,
    input  logic [CW_W-1:0]       cw_word,
    input  logic [NUM_TECH-1:0]   link_ready,
    input  logic                  timer_exp,
    input  logic                  np_local,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [CW_W-1:0]       rd_data
);
    logic            page_evt;
    logic [CW_W-1:0] page_word;
    logic            fault_evt;
    exp_stat_t       stat;

    an_cw_matcher #(.MATCH_CNT(MATCH_CNT)) u_match (
        .clk       (clk),
        .rst       (rst),
        .cw_valid  (cw_valid),
        .cw_word   (cw_word),
        .page_evt  (page_evt),
        .page_word (page_word)
    );

    an_pd_detect #(.NUM_TECH(NUM_TECH)) u_pd (
        .link_ready (link_ready),
        .timer_exp  (timer_exp),
        .fault_evt  (fault_evt)
    );

    an_stat_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .page_evt  (page_evt),
        .page_word (page_word),
        .fault_evt (fault_evt),
        .np_local  (np_local),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .stat      (stat),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/an_page_status_chk.sv
module an_page_status_chk
    import an_pkg::*;
#(
    parameter int unsigned NUM_TECH = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_TECH-1:0]   link_ready,
    input logic                  timer_exp,
    input logic                  rd_en,
    input logic [REG_ADDR_W-1:0] rd_addr,
    input logic                  page_evt,
    input logic                  fault_evt,
    input exp_stat_t             stat
);
    // R1
    page_sets_chk: assert property (@(posedge clk) disable iff (rst)
        page_evt |=> stat.prcvd);

    // R1
    page_only_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.prcvd) |-> $past(page_evt));

    // R6
    prcvd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == ADDR_EXP && !page_evt) |=> !stat.prcvd);

    // R6
    fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == ADDR_EXP && !fault_evt) |=> !stat.fault);

    // R7
    pd_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (timer_exp && $countones(link_ready) != 1) |=> stat.fault);

    // R7
    pd_no_timer_chk: assert property (@(posedge clk) disable iff (rst)
        !timer_exp |-> !fault_evt);

    // R10
    lpana_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stat.lpana |=> stat.lpana);

endmodule

bind an_page_status an_page_status_chk #(.NUM_TECH(NUM_TECH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_ready (link_ready),
    .timer_exp  (timer_exp),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .page_evt   (page_evt),
    .fault_evt  (fault_evt),
    .stat       (stat)
);

// File: tb/an_page_status_tb.sv
module an_page_status_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cw_valid;
    logic [15:0] cw_word;
    logic [2:0]  link_ready;
    logic        timer_exp;
    logic        np_local;
    logic        rd_en;
    logic [4:0]  rd_addr;
    logic [15:0] rd_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    localparam logic [15:0] WA = 16'h41E1;
    localparam logic [15:0] WB = 16'h8001;
    localparam logic [15:0] WC = 16'h0123;

    always #5 clk = ~clk;

    an_page_status u_dut (
        .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_word(cw_word),
        .link_ready(link_ready), .timer_exp(timer_exp), .np_local(np_local),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<50000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cw_valid = 1'b1;
        cw_word  = w;
        @(negedge clk);
        cw_valid = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en   = 1'b0;
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic clr_read(output logic [15:0] pre, output logic [15:0] post);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = 5'd6;
        #1 pre = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
        #1 post = rd_data;
    endtask

    task automatic pd_pulse(input logic [2:0] rdy);
        @(negedge clk);
        link_ready = rdy;
        timer_exp  = 1'b1;
        @(negedge clk);
        timer_exp  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        peek(5'd6, d); chk("R9 status after reset", d, 16'h0000);
        peek(5'd5, d); chk("R9 partner after reset", d, 16'h0000);
    endtask

    task automatic t_three_match();
        logic [15:0] d, pre, post;
        send(WA); send(WA);
        peek(5'd6, d); chk("R1 two words not enough", d, 16'h0000);
        // cw_valid low with the same word must not count
        @(negedge clk); cw_word = WA;
        @(negedge clk);
        peek(5'd6, d); chk("R1 invalid word ignored", d, 16'h0000);
        send(WA);
        peek(5'd6, d); chk("R1 third word sets page", d, 16'h0003);
        peek(5'd5, d); chk("R4 partner word stored", d, WA);
        clr_read(pre, post);
        chk("R6 read shows pre-clear", pre, 16'h0003);
        chk("R6 cleared after read", post, 16'h0001);
    endtask

    task automatic t_no_repeat();
        logic [15:0] d;
        send(WA); send(WA);
        peek(5'd6, d); chk("R3 repeat of accepted page", d, 16'h0001);
    endtask

    task automatic t_restart();
        logic [15:0] d, pre, post;
        send(WB); send(WB); send(WA); send(WB); send(WB);
        peek(5'd6, d); chk("R2 broken run no page", d, 16'h0001);
        peek(5'd5, d); chk("R4 partner unchanged", d, WA);
        send(WB);
        peek(5'd6, d); chk("R2 R5 page with next-page bit", d, 16'h000B);
        peek(5'd5, d); chk("R4 new partner word", d, WB);
        clr_read(pre, post);
        chk("R10 lpana survives read", post, 16'h0009);
    endtask

    task automatic t_local_np();
        logic [15:0] d;
        @(negedge clk); np_local = 1'b1;
        peek(5'd6, d); chk("R5 local next-page bit", d, 16'h000D);
        @(negedge clk); np_local = 1'b0;
        peek(5'd6, d); chk("R5 upper bits zero", d & 16'hFFE0, 16'h0000);
    endtask

    task automatic t_fault();
        logic [15:0] d, pre, post;
        pd_pulse(3'b001);
        peek(5'd6, d); chk("R7 single ready no fault", d, 16'h0009);
        @(negedge clk); link_ready = 3'b000;
        @(negedge clk); @(negedge clk);
        peek(5'd6, d); chk("R7 no timer no fault", d, 16'h0009);
        pd_pulse(3'b000);
        peek(5'd6, d); chk("R7 zero ready fault", d, 16'h0019);
        clr_read(pre, post);
        chk("R6 fault cleared", post, 16'h0009);
        pd_pulse(3'b011);
        peek(5'd6, d); chk("R7 two ready fault", d, 16'h0019);
        clr_read(pre, post);
        pd_pulse(3'b111);
        peek(5'd6, d); chk("R7 three ready fault", d, 16'h0019);
        clr_read(pre, post);
        chk("R6 fault cleared again", post, 16'h0009);
    endtask

    task automatic t_set_wins();
        logic [15:0] d, pre;
        send(WC); send(WC);
        @(negedge clk);
        cw_valid = 1'b1; cw_word = WC;
        rd_en = 1'b1; rd_addr = 5'd6;
        link_ready = 3'b000; timer_exp = 1'b1;
        #1 pre = rd_data;
        @(negedge clk);
        cw_valid = 1'b0; rd_en = 1'b0; timer_exp = 1'b0;
        chk("R8 read before edge", pre, 16'h0009);
        peek(5'd6, d); chk("R8 set wins over clear", d, 16'h0013);
    endtask

    task automatic t_other_addr();
        logic [15:0] d;
        peek(5'd0, d);  chk("R11 addr 0 reads zero", d, 16'h0000);
        peek(5'd7, d);  chk("R11 addr 7 reads zero", d, 16'h0000);
        peek(5'd31, d); chk("R11 addr 31 reads zero", d, 16'h0000);
    endtask

    task automatic t_final_reset();
        logic [15:0] d;
        do_reset();
        peek(5'd6, d); chk("R9 R10 lpana cleared by reset", d, 16'h0000);
        peek(5'd5, d); chk("R9 partner cleared by reset", d, 16'h0000);
        send(WC); send(WC);
        peek(5'd6, d); chk("R9 match count cleared", d, 16'h0000);
    endtask

    initial begin
        rst = 1'b1; cw_valid = 1'b0; cw_word = '0; link_ready = '0;
        timer_exp = 1'b0; np_local = 1'b0; rd_en = 1'b0; rd_addr = '0;
        t_reset();
        t_three_match();
        t_no_repeat();
        t_restart();
        t_local_np();
        t_fault();
        t_set_wins();
        t_other_addr();
        t_final_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule